// File: doc/BRIEF.md
# Parallel Self-Synchronizing Lane Descrambler

This block takes the scrambled payload of one serial link lane, presented as a 16-bit parallel word per clock, and returns the original user data. The descrambling follows the recurrence of the polynomial 1 + x^14 + x^15. Each recovered bit is formed from received scrambled bits only, so the block needs no seed, training pattern or lock handshake. Once 15 scrambled bits have passed through, its output is correct whatever its history held before.

A word is accepted when the input strobe is high. The result appears one clock later with a matching output strobe. A mode input selects descrambling or a plain pass-through, and both settings have the same single-register latency. The block's only state is the last 15 scrambled bits it has received. That history is updated on every accepted word in either mode, so switching modes never costs a resynchronization.

Top module: `lane_descrambler16`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_vld` is 0 and `out_word` is 0.
- R2: `out_vld` equals the value `in_vld` had on the previous rising clock edge.
- R3: With `descr_on` = 1, bit i of the result is the received bit XOR the scrambled bits received 14 and 15 bit times earlier. Bit 15 of a word is the earliest in serial order and bit 0 is the latest. Bits within one word may draw on earlier bits of the same word.
- R4: With `descr_on` = 0, an accepted word appears unchanged on `out_word` one cycle later.
- R5: A cycle with `in_vld` = 0 leaves `out_word` unchanged and has no effect on the history, whatever `in_word` carries. The next accepted word is recovered as if the idle cycle had not occurred.
- R6: After any 15 accepted scrambled bits, every later result is correct, whatever the history contained before.
- R7: The history also records the words accepted in pass-through mode. The first word descrambled after a switch from pass-through is therefore already correct.
- R8: `descr_on` is sampled together with each accepted word, so the mode can change from one word to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| descr_on | input | 1 | 1 = descramble, 0 = pass through |
| in_vld | input | 1 | Input word strobe |
| in_word | input | 16 | Scrambled input word, MSB earliest |
| out_vld | output | 1 | Output word strobe |
| out_word | output | 16 | Recovered (or passed-through) word |

## Verification
The bench builds the block with its default parameters: a 16-bit word and taps at 14 and 15. Because the word is wider than the 15-bit history, a single accepted word is enough to refill the history. That makes R6 observable within two words of a deliberately mismatched start. Including the lowest bits of every word in the checks exercises the intra-word dependency, where bit 0 draws entirely on bits of its own word.

// File: rtl/lane_descrambler16.sv
module lane_descrambler16 #(
  parameter int DATA_W   = 16,
  parameter int TAP_NEAR = 14,
  parameter int TAP_FAR  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              descr_on,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_word,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_word
);
  localparam int HIST_W = TAP_FAR;
  localparam int CAT_W  = HIST_W + DATA_W;

  logic [HIST_W-1:0] hist_q;
  logic [CAT_W-1:0]  stream;
  logic [DATA_W-1:0] plain;

  // higher index = earlier in serial order
  assign stream = {hist_q, in_word};

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign plain[i] = stream[i] ^ stream[i+TAP_NEAR] ^ stream[i+TAP_FAR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q   <= '0;
      out_vld  <= 1'b0;
      out_word <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        hist_q   <= stream[HIST_W-1:0];
        out_word <= descr_on ? plain : in_word;
      end
    end
  end
endmodule

// File: rtl/lane_descrambler16_chk.sv
module lane_descrambler16_chk #(
  parameter int DATA_W = 16,
  parameter int HIST_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              descr_on,
  input logic              in_vld,
  input logic [DATA_W-1:0] in_word,
  input logic              out_vld,
  input logic [DATA_W-1:0] out_word,
  input logic [HIST_W-1:0] hist_q
);
  assert_vld_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  assert_vld_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  assert_bypass_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !descr_on) |=> out_word == $past(in_word));
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_word) && $stable(hist_q)));
endmodule

bind lane_descrambler16 lane_descrambler16_chk #(.DATA_W(DATA_W), .HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .descr_on(descr_on), .in_vld(in_vld),
  .in_word(in_word), .out_vld(out_vld), .out_word(out_word), .hist_q(hist_q)
);

// File: tb/test_lane_descrambler16.sv
`timescale 1ns/1ps
module test_lane_descrambler16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        descr_on = 1'b1;
  logic        in_vld = 1'b0;
  logic [15:0] in_word = '0;
  logic        out_vld;
  logic [15:0] out_word;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [14:0] sst = '0;     // bench scrambler state, bit 0 most recent
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  lane_descrambler16 i_lane_descrambler16 (
    .clk(clk), .rst_n(rst_n), .descr_on(descr_on), .in_vld(in_vld),
    .in_word(in_word), .out_vld(out_vld), .out_word(out_word)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scramble(input logic [15:0] d, output logic [15:0] s);
    for (int i = 15; i >= 0; i--) begin
      s[i] = d[i] ^ sst[13] ^ sst[14];
      sst  = {sst[13:0], s[i]};
    end
  endtask

  function automatic logic [15:0] next_pat();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  // drive one word, check one cycle later
  task automatic push(input logic [15:0] w, input logic mode, input string req,
                      input logic [15:0] exp, input bit chk);
    @(negedge clk);
    in_word = w; descr_on = mode; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
    check("R2", {15'd0, out_vld}, 16'd1);
    if (chk) check(req, out_word, exp);
  endtask

  task automatic t_reset();
    check("R1", {15'd0, out_vld}, 16'd0);
    check("R1", out_word, 16'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", {15'd0, out_vld}, 16'd0);
    check("R1", out_word, 16'd0);
  endtask

  task automatic t_descramble();
    logic [15:0] pats[4] = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h0001};
    logic [15:0] s;
    foreach (pats[k]) begin scramble(pats[k], s); push(s, 1'b1, "R3", pats[k], 1'b1); end
    for (int k = 0; k < 20; k++) begin
      logic [15:0] d = next_pat();
      scramble(d, s); push(s, 1'b1, "R3", d, 1'b1);
    end
  endtask

  task automatic t_idle();
    logic [15:0] last = out_word, s, d;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_word = next_pat(); in_vld = 1'b0;
      @(negedge clk);
      check("R5", {15'd0, out_vld}, 16'd0);
      check("R5", out_word, last);
    end
    d = next_pat(); scramble(d, s); push(s, 1'b1, "R5", d, 1'b1);
  endtask

  task automatic t_bypass_switch();
    logic [15:0] s, d;
    for (int k = 0; k < 5; k++) begin
      d = next_pat(); scramble(d, s); push(s, 1'b0, "R4", s, 1'b1);
    end
    d = next_pat(); scramble(d, s); push(s, 1'b1, "R7", d, 1'b1);
    d = next_pat(); scramble(d, s); push(s, 1'b0, "R8", s, 1'b1);
    d = next_pat(); scramble(d, s); push(s, 1'b1, "R8", d, 1'b1);
  endtask

  task automatic t_selfsync();
    logic [15:0] s, d;
    sst = 15'h5A3C;          // scrambler history unknown to the block
    d = next_pat(); scramble(d, s); push(s, 1'b1, "R6", d, 1'b0);
    for (int k = 0; k < 10; k++) begin
      d = next_pat(); scramble(d, s); push(s, 1'b1, "R6", d, 1'b1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_descramble();
    t_idle();
    t_bypass_switch();
    t_selfsync();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule